// File: doc/BRIEF.md
# Variable-Width Finite Pulse Sequencer

The block drives a single digital line with a finite burst of pulses in which every pulse carries its own high duration, while all pulses share one low duration. A host pushes per-pulse high times, counted in system-clock ticks, into an internal first-in first-out store through a one-cycle write strobe. It presents the low time and the number of pulses on static inputs and then pulses a start strobe. The sequencer pops one width per pulse and plays the list back exactly and in load order. A typical burst is twenty pulses, each high for between a few thousand and a hundred thousand ticks, separated by a fixed gap.

While the burst runs, a busy output stays high. A one-cycle done strobe marks the end of the burst, whether it ran to its count, was aborted by the stop input, or ran out of widths. Running out of widths also raises a sticky underflow flag, which clears on the next accepted start. Widths may be pushed while a burst is running, so a host can stream a list longer than the store.

Top module: `pulse_seq_top`

## Requirements
- R1: After reset pulse_o, busy_o, done_o, underflow_o and full_o are 0 and empty_o is 1.
- R2: Each pulse stays high for exactly the number of ticks popped for it, a value of 0 counting as 1. Widths are consumed in the order they were written.
- R3: Between pulses, and after the last pulse, the line stays low for the latched low_ticks_i ticks, a value of 0 counting as 1.
- R4: A burst emits pulse_num_i pulses. In the cycle after the last low tick, busy_o falls and done_o is high for that one cycle. A pulse count of 0 gives done_o in the cycle after start with no pulse and no FIFO read.
- R5: A start strobe seen while busy_o is high has no effect. The burst keeps its count and consumes no extra widths.
- R6: A stop strobe while busy forces pulse_o and busy_o to 0 in the next cycle, with done_o high in that cycle. Widths not yet popped stay in the FIFO in order.
- R7: If the FIFO is empty when a pulse is due, including at start, the burst ends with done_o and underflow_o is set to 1. underflow_o returns to 0 on the next accepted start.
- R8: The FIFO holds FIFO_DEPTH (default 32) widths. full_o is 1 when it holds that many, and a write while full is dropped. empty_o is 1 when it holds none.
- R9: With a nonzero count and a nonempty FIFO, pulse_o and busy_o are 1 in the cycle right after the cycle in which start_i is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, the time base |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Push wr_data_i into the width FIFO |
| wr_data_i | input | CNT_W | High time of one pulse, in ticks |
| low_ticks_i | input | CNT_W | Shared low time, latched at start |
| pulse_num_i | input | NUM_W | Pulses per burst, latched at start |
| start_i | input | 1 | Start strobe, acted on only when idle |
| stop_i | input | 1 | Abort strobe |
| pulse_o | output | 1 | Pulse line, idles low |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst strobe |
| underflow_o | output | 1 | Sticky: the last burst ran out of widths |
| full_o | output | 1 | Width FIFO full |
| empty_o | output | 1 | Width FIFO empty |

## Verification
The hardest case to reach from the ports is a FIFO running dry in the middle of a burst after an earlier write was dropped because the FIFO was full. The bench reaches it by writing one entry more than the FIFO depth while idle, then asking for that many pulses. This must yield exactly a depth's worth of pulses in order, followed by the underflow end. Stop and start-while-busy are injected at chosen sample points inside a running burst. A second burst then shows the widths left in the FIFO still in order.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } pseq_state_e;
endpackage

// File: rtl/pseq_fifo.sv
module pseq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == FULL_CNT);
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= CNT_W'(1);
    else if (load_i)           cnt <= (load_val_i == '0) ? CNT_W'(1) : load_val_i;
    else if (cnt > CNT_W'(1))  cnt <= cnt - 1'b1;
  end

  assign last_o = (cnt == CNT_W'(1));
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import pseq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NUM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] low_ticks_i,
  input  logic [NUM_W-1:0] pulse_num_i,
  input  logic [CNT_W-1:0] head_i,
  input  logic             fifo_empty_i,
  input  logic             tmr_last_i,
  output logic             pop_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             pulse_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underflow_o
);
  pseq_state_e      state;
  logic [NUM_W-1:0] left;
  logic [CNT_W-1:0] low_q;
  logic             go, last_pulse;

  assign go         = start_i && !stop_i;
  assign last_pulse = (left == NUM_W'(1));

  always_comb begin
    pop_o      = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = head_i;
    unique case (state)
      ST_IDLE: if (go && pulse_num_i != '0 && !fifo_empty_i) begin
        pop_o      = 1'b1;
        tmr_load_o = 1'b1;
      end
      ST_HIGH: if (!stop_i && tmr_last_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = low_q;
      end
      ST_LOW: if (!stop_i && tmr_last_i && !last_pulse && !fifo_empty_i) begin
        pop_o      = 1'b1;
        tmr_load_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      left        <= '0;
      low_q       <= '0;
      done_o      <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (go) begin
          underflow_o <= 1'b0;
          low_q       <= low_ticks_i;
          left        <= pulse_num_i;
          if (pulse_num_i == '0) begin
            done_o <= 1'b1;
          end else if (fifo_empty_i) begin
            done_o      <= 1'b1;
            underflow_o <= 1'b1;
          end else begin
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (stop_i) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end else if (tmr_last_i) begin
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (stop_i) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end else if (tmr_last_i) begin
            if (last_pulse) begin
              state  <= ST_IDLE;
              done_o <= 1'b1;
            end else if (fifo_empty_i) begin
              state       <= ST_IDLE;
              done_o      <= 1'b1;
              underflow_o <= 1'b1;
            end else begin
              state <= ST_HIGH;
              left  <= left - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pulse_o = (state == ST_HIGH);
  assign busy_o  = (state != ST_IDLE);
endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top #(
  parameter int CNT_W      = 16,
  parameter int NUM_W      = 8,
  parameter int FIFO_DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] low_ticks_i,
  input  logic [NUM_W-1:0] pulse_num_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             pulse_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underflow_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] head, tmr_val;
  logic             pop, tmr_load, tmr_last;

  pseq_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_en_i),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .full_o      (full_o),
    .empty_o     (empty_o)
  );

  pseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .last_o     (tmr_last)
  );

  pseq_ctrl #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .low_ticks_i  (low_ticks_i),
    .pulse_num_i  (pulse_num_i),
    .head_i       (head),
    .fifo_empty_i (empty_o),
    .tmr_last_i   (tmr_last),
    .pop_o        (pop),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .pulse_o      (pulse_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .underflow_o  (underflow_o)
  );
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic stop_i,
  input logic pulse_o,
  input logic busy_o,
  input logic done_o,
  input logic underflow_o,
  input logic full_o,
  input logic empty_o
);
  // R3: line idles low
  a_r3_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !pulse_o);

  // R4: every end of a burst carries done
  a_r4_done_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R4: done never overlaps busy
  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R6: stop ends the burst in the next cycle
  a_r6_stop_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && busy_o) |=> (!pulse_o && !busy_o && done_o));

  // R7: underflow is raised only together with done
  a_r7_uf_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> done_o);

  // R8: full and empty exclusive
  a_r8_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  // R5: start while busy does not end the burst by itself
  a_r5_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !stop_i && pulse_o) |=> busy_o);
endmodule

bind pulse_seq_top pseq_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .pulse_o     (pulse_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .underflow_o (underflow_o),
  .full_o      (full_o),
  .empty_o     (empty_o)
);

// File: tb/sim_pulse_seq_top.sv
module sim_pulse_seq_top;
  localparam int CNT_W = 16;
  localparam int NUM_W = 8;
  localparam int DEPTH = 32;

  localparam int NV = 4;
  localparam int VN [NV]     = '{3, 4, 1, 2};
  localparam int VL [NV]     = '{2, 0, 4, 1};
  localparam int VW [NV][4]  = '{'{5, 1, 3, 0}, '{0, 2, 7, 1}, '{9, 0, 0, 0}, '{1, 1, 0, 0}};

  logic             clk_i = 0, rst_ni = 0;
  logic             wr_en_i = 0, start_i = 0, stop_i = 0;
  logic [CNT_W-1:0] wr_data_i = '0, low_ticks_i = '0;
  logic [NUM_W-1:0] pulse_num_i = '0;
  logic             pulse_o, busy_o, done_o, underflow_o, full_o, empty_o;

  int checks = 0, fails = 0;
  int meas_h [64];
  int meas_l [64];
  int nh, nl;
  logic first_pulse, first_busy;

  always #5 clk_i = ~clk_i;

  pulse_seq_top #(.CNT_W(CNT_W), .NUM_W(NUM_W), .FIFO_DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic push(input int w);
    @(negedge clk_i);
    wr_en_i = 1; wr_data_i = CNT_W'(w);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  // start, then record run lengths until done; optional injected strobes
  task automatic run(input int n, input int l, input int poke_start, input int poke_stop);
    int prev, rl, k;
    @(negedge clk_i);
    start_i = 1; pulse_num_i = NUM_W'(n); low_ticks_i = CNT_W'(l);
    @(negedge clk_i);
    start_i = 0;
    first_pulse = pulse_o; first_busy = busy_o;
    prev = 0; rl = 0; nh = 0; nl = 0; k = 0;
    while (!done_o && k < 5000) begin
      if (pulse_o == prev) rl++;
      else begin
        if (prev == 1) begin meas_h[nh] = rl; nh++; end
        else if (nh > 0) begin meas_l[nl] = rl; nl++; end
        prev = int'(pulse_o); rl = 1;
      end
      start_i = (k == poke_start);
      stop_i  = (k == poke_stop);
      k++;
      @(negedge clk_i);
    end
    start_i = 0; stop_i = 0;
    if (k >= 5000) chk(0, "watchdog", k, 0);
    if (prev == 1) begin meas_h[nh] = rl; nh++; end
    else if (nh > 0) begin meas_l[nl] = rl; nl++; end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(pulse_o == 0 && busy_o == 0 && done_o == 0, "R1 outputs", int'({pulse_o, busy_o, done_o}), 0);
    chk(empty_o == 1 && full_o == 0 && underflow_o == 0, "R1 flags", int'({empty_o, full_o, underflow_o}), 4);
    rst_ni = 1;

    // table walk: R2 R3 R4 R9
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < VN[v]; i++) push(VW[v][i]);
      run(VN[v], VL[v], -1, -1);
      chk(first_pulse && first_busy, "R9 first cycle", int'({first_pulse, first_busy}), 3);
      chk(nh == VN[v], "R4 pulse count", nh, VN[v]);
      for (int i = 0; i < VN[v]; i++) begin
        chk(meas_h[i] == eff(VW[v][i]), "R2 high width", meas_h[i], eff(VW[v][i]));
        chk(meas_l[i] == eff(VL[v]), "R3 low width", meas_l[i], eff(VL[v]));
      end
      chk(done_o && !busy_o && !underflow_o, "R4 done strobe", int'({done_o, busy_o, underflow_o}), 4);
      @(negedge clk_i);
      chk(!done_o, "R4 done one cycle", int'(done_o), 0);
    end

    // R5 start while busy ignored
    push(4); push(4); push(6); push(8);
    run(2, 3, 2, -1);
    chk(nh == 2, "R5 count kept", nh, 2);
    @(negedge clk_i);
    chk(!busy_o && !empty_o, "R5 no extra burst", int'({busy_o, empty_o}), 0);
    run(2, 1, -1, -1);
    chk(nh == 2 && meas_h[0] == 6 && meas_h[1] == 8, "R5 widths unconsumed", meas_h[0], 6);

    // R6 stop mid-pulse keeps remaining widths
    push(10); push(11); push(12);
    run(3, 2, -1, 4);
    chk(nh == 1 && meas_h[0] == 5, "R6 stop cut", meas_h[0], 5);
    chk(!pulse_o && !busy_o && done_o, "R6 stop state", int'({pulse_o, busy_o, done_o}), 1);
    run(2, 2, -1, -1);
    chk(nh == 2 && meas_h[0] == 11 && meas_h[1] == 12, "R6 remaining order", meas_h[0], 11);
    chk(empty_o, "R6 drained", int'(empty_o), 1);

    // R7 underflow mid-burst and at start
    push(3); push(2);
    run(5, 2, -1, -1);
    chk(nh == 2 && nl == 2, "R7 early end", nh, 2);
    chk(underflow_o && done_o, "R7 flag", int'({underflow_o, done_o}), 3);
    run(1, 1, -1, -1);
    chk(nh == 0 && underflow_o, "R7 empty start", nh, 0);
    push(2);
    @(negedge clk_i); start_i = 1; pulse_num_i = 1;
    @(negedge clk_i); start_i = 0;
    chk(!underflow_o && pulse_o, "R7 cleared on start", int'(underflow_o), 0);
    repeat (6) @(negedge clk_i);

    // R4 zero count
    push(7);
    run(0, 1, -1, -1);
    chk(nh == 0 && !first_busy && !empty_o, "R4 zero count", nh, 0);
    run(1, 1, -1, -1);
    chk(meas_h[0] == 7, "R4 zero count no pop", meas_h[0], 7);

    // R8 full, dropped write, then underflow after DEPTH pulses
    for (int i = 0; i < DEPTH; i++) push(i % 3 + 1);
    chk(full_o && !empty_o, "R8 full", int'(full_o), 1);
    push(9);
    run(DEPTH + 1, 0, -1, -1);
    chk(nh == DEPTH, "R8 drop extra", nh, DEPTH);
    chk(underflow_o, "R8 underflow after drop", int'(underflow_o), 1);
    for (int i = 0; i < DEPTH; i++)
      chk(meas_h[i] == i % 3 + 1, "R8 order", meas_h[i], i % 3 + 1);
    chk(empty_o && !full_o, "R8 empty", int'({empty_o, full_o}), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule